// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Right-Shift Unit with Stored Flags

This unit performs the arithmetic and right-shift work of a small 8-bit processor. It receives a destination operand `a_i` and a source operand `b_i`, plus a 4-bit operation code. It returns the result combinationally. The result depends on the current inputs and on the stored carry. The processor routes the source operand through the unit unchanged when it executes register moves.

The unit holds two flags, carry and zero, in one register. The register loads only on a clock edge where `flag_we_i` is high. A synchronous reset clears both flags. Subtract-with-carry is defined as `a + ~b + C`, which equals `a - b - 1 + C`. This is not the usual borrow form. Every right shift and rotate moves the old bit 0 into the carry.

Top module: `carry_alu`

## Requirements
- R1: Op 4'b1000 (ADD) gives `a + b` and op 4'b1001 (ADC) gives `a + b + C`, where C is the stored carry. With `flag_we_i` high, the carry loads the carry out of bit 7.
- R2: Op 4'b1010 (SUB) gives `a + ~b + 1` and op 4'b1011 (SBC) gives `a + ~b + C`. With `flag_we_i` high, the carry loads the carry out of that sum, so carry=1 means no borrow.
- R3: Op 4'b0100 (INC) gives `a + 1` and op 4'b0101 (DEC) gives `a - 1`, both modulo 256. The carry flag is left unchanged and only the zero flag may update.
- R4: The shift ops all give `{top, a[7:1]}` and load the old `a[0]` into the carry. The value of `top` depends on the op:
  - 4'b1100 (ASR): old `a[7]`
  - 4'b1101 (LSR): 0
  - 4'b1110 (ROR): old `a[0]`
  - 4'b1111 (RRC): the stored carry
- R5: Op 4'b0000 (move) outputs `b` unchanged and leaves both flags unchanged. The codes 4'b0001, 4'b0010, 4'b0011, 4'b0110 and 4'b0111 behave the same way.
- R6: For every flag-updating op with `flag_we_i` high, the zero flag loads 1 exactly when the 8-bit result is 0x00.
- R7: With `flag_we_i` low, neither flag changes on a clock edge, whatever the op.
- R8: A synchronous reset `rst` clears both the carry and the zero flag.
- R9: The result output follows its inputs combinationally. It uses the currently stored carry, not a carry produced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 8 | Destination operand |
| b_i | input | 8 | Source operand |
| op_i | input | 4 | Operation code |
| flag_we_i | input | 1 | Enables the flag register to load |
| result_o | output | 8 | Combinational result |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | Stored zero flag |

## Verification
The bench builds the unit with its default width of 8. At that width the wrap-around corners can be reached directly, and random operand pairs cover the operand space densely:
- 0xFF+1
- 0x00-1
- equal-operand subtraction
- rotates through bit 7

Random runs chain operations so that ADC, SBC and RRC consume a carry left behind by earlier operations. These runs also toggle the flag enable, which exercises the hold path.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_MOVE = 4'b0000,
        OP_INC  = 4'b0100,
        OP_DEC  = 4'b0101,
        OP_ADD  = 4'b1000,
        OP_ADC  = 4'b1001,
        OP_SUB  = 4'b1010,
        OP_SBC  = 4'b1011,
        OP_ASR  = 4'b1100,
        OP_LSR  = 4'b1101,
        OP_ROR  = 4'b1110,
        OP_RRC  = 4'b1111
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } flags_t;

    function automatic logic op_is_arith(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    function automatic logic op_is_step(input logic [3:0] op);
        return op[3:1] == 3'b010;
    endfunction

    function automatic logic op_is_shift(input logic [3:0] op);
        return op[3:2] == 2'b11;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         inv_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    localparam int EW = W + 1;

    logic [W-1:0] y_eff;
    logic [EW-1:0] wide;

    always_comb begin
        y_eff = inv_i ? ~y_i : y_i;
        wide  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, cin_i};
    end

    assign sum_o  = wide[W-1:0];
    assign cout_o = wide[W];
endmodule

// File: rtl/alu_rshift.sv
module alu_rshift #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [1:0]   mode_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    logic top_bit;

    always_comb begin
        case (mode_i)
            2'd0:    top_bit = x_i[W-1];
            2'd1:    top_bit = 1'b0;
            2'd2:    top_bit = x_i[0];
            default: top_bit = cin_i;
        endcase
        res_o  = {top_bit, x_i[W-1:1]};
        cout_o = x_i[0];
    end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    input  logic             flag_we_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    flags_t flags_d, flags_q;

    logic [WIDTH-1:0] add_y_d;
    logic             add_inv_d, add_cin_d;
    logic [WIDTH-1:0] sum_w, shf_w;
    logic             sum_cout_w, shf_cout_w;
    logic [WIDTH-1:0] result_d;

    always_comb begin
        add_y_d   = b_i;
        add_inv_d = 1'b0;
        add_cin_d = 1'b0;
        if (op_is_arith(op_i)) begin
            add_inv_d = op_i[1];
            add_cin_d = op_i[0] ? flags_q.carry : op_i[1];
        end else if (op_is_step(op_i)) begin
            add_y_d   = ONE;
            add_inv_d = op_i[0];
            add_cin_d = op_i[0];
        end
    end

    alu_addsub #(.W(WIDTH)) i_addsub (
        .x_i    (a_i),
        .y_i    (add_y_d),
        .inv_i  (add_inv_d),
        .cin_i  (add_cin_d),
        .sum_o  (sum_w),
        .cout_o (sum_cout_w)
    );

    alu_rshift #(.W(WIDTH)) i_rshift (
        .x_i    (a_i),
        .mode_i (op_i[1:0]),
        .cin_i  (flags_q.carry),
        .res_o  (shf_w),
        .cout_o (shf_cout_w)
    );

    always_comb begin
        flags_d = flags_q;
        if (op_is_arith(op_i) || op_is_step(op_i)) begin
            result_d = sum_w;
        end else if (op_is_shift(op_i)) begin
            result_d = shf_w;
        end else begin
            result_d = b_i;
        end
        if (flag_we_i) begin
            if (op_is_arith(op_i) || op_is_shift(op_i)) begin
                flags_d.carry = op_is_arith(op_i) ? sum_cout_w : shf_cout_w;
                flags_d.zero  = (result_d == '0);
            end else if (op_is_step(op_i)) begin
                flags_d.zero  = (result_d == '0);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign result_o = result_d;
    assign carry_o  = flags_q.carry;
    assign zero_o   = flags_q.zero;

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!carry_o && !zero_o));

    // R7
    hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we_i |=> ($stable(carry_o) && $stable(zero_o)));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && (op_i[3] || op_is_step(op_i)))
        |=> (zero_o == ($past(result_o) == '0)));

    // R3
    step_keeps_carry_chk: assert property (@(posedge clk) disable iff (rst)
        op_is_step(op_i) |=> $stable(carry_o));

    // R4
    shift_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we_i && op_is_shift(op_i)) |=> (carry_o == $past(a_i[0])));

    // R5
    move_passes_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_MOVE) |-> (result_o == b_i));
endmodule

// File: tb/test_carry_alu.sv
`timescale 1ns/1ps
module test_carry_alu;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a, b;
    logic [3:0] op;
    logic       we;
    logic [7:0] res;
    logic       cf, zf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic m_c, m_z;

    always #10 clk = ~clk;

    carry_alu i_carry_alu (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op),
        .flag_we_i(we), .result_o(res), .carry_o(cf), .zero_o(zf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'b1000, 4'b1001: return "R1";
            4'b1010, 4'b1011: return "R2";
            4'b0100, 4'b0101: return "R3";
            4'b1100, 4'b1101, 4'b1110, 4'b1111: return "R4";
            default: return "R5";
        endcase
    endfunction

    // expected {update_carry, update_zero, carry_out, result}
    function automatic logic [10:0] model(input logic [7:0] x, input logic [7:0] y,
                                          input logic [3:0] o, input logic c);
        int s;
        case (o)
            4'b1000: begin s = x + y;           return {2'b11, s[8], s[7:0]}; end
            4'b1001: begin s = x + y + c;       return {2'b11, s[8], s[7:0]}; end
            4'b1010: begin s = x + (255 - y) + 1; return {2'b11, s[8], s[7:0]}; end
            4'b1011: begin s = x + (255 - y) + c; return {2'b11, s[8], s[7:0]}; end
            4'b0100: begin s = (x + 1) % 256;   return {2'b01, 1'b0, s[7:0]}; end
            4'b0101: begin s = (x + 255) % 256; return {2'b01, 1'b0, s[7:0]}; end
            4'b1100: return {2'b11, x[0], x[7], x[7:1]};
            4'b1101: return {2'b11, x[0], 1'b0, x[7:1]};
            4'b1110: return {2'b11, x[0], x[0], x[7:1]};
            4'b1111: return {2'b11, x[0], c, x[7:1]};
            default: return {3'b000, y};
        endcase
    endfunction

    task automatic do_op(input logic [7:0] x, input logic [7:0] y,
                         input logic [3:0] o, input logic w);
        logic [10:0] e;
        @(negedge clk);
        a = x; b = y; op = o; we = w;
        #2;
        e = model(x, y, o, m_c);
        // R9: result is combinational and uses the stored carry
        check(res == e[7:0], {req_of(o), "/R9 result"}, res, e[7:0]);
        @(posedge clk);
        if (w) begin
            if (e[10]) m_c = e[8];
            if (e[9])  m_z = (e[7:0] == 8'h00);
        end
        #2;
        // R6 zero flag, R7 hold when disabled
        check(cf == m_c, {req_of(o), w ? "/R6 carry" : "/R7 carry"}, cf, m_c);
        check(zf == m_z, {req_of(o), w ? "/R6 zero" : "/R7 zero"}, zf, m_z);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; a = 8'h00; b = 8'h00; op = 4'b0000; we = 1'b1;
        m_c = 1'b0; m_z = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(cf == 1'b0, "R8 carry after reset", cf, 0);
        check(zf == 1'b0, "R8 zero after reset", zf, 0);
        @(negedge clk); rst = 1'b0;

        do_op(8'hFF, 8'h01, 4'b1000, 1'b1);   // R1 wrap to zero, carry 1
        check(cf == 1'b1 && zf == 1'b1, "R1 0xFF+1 flags", {cf, zf}, 3);
        do_op(8'h10, 8'h20, 4'b1001, 1'b1);   // R1 ADC with C=1 -> 0x31
        do_op(8'h05, 8'h05, 4'b1010, 1'b1);   // R2 equal operands
        check(cf == 1'b1 && zf == 1'b1, "R2 5-5 flags", {cf, zf}, 3);
        do_op(8'h03, 8'h05, 4'b1010, 1'b1);   // R2 borrow -> carry 0
        do_op(8'h05, 8'h05, 4'b1011, 1'b1);   // R2 SBC with C=0 -> 0xFF
        do_op(8'hFF, 8'h00, 4'b0100, 1'b1);   // R3 INC wraps to 0
        do_op(8'h00, 8'h00, 4'b0101, 1'b1);   // R3 DEC wraps to 0xFF
        do_op(8'h81, 8'h00, 4'b1100, 1'b1);   // R4 ASR
        do_op(8'h02, 8'h00, 4'b1111, 1'b1);   // R4 RRC with C=1 -> 0x81
        do_op(8'h01, 8'h00, 4'b1110, 1'b1);   // R4 ROR -> 0x80
        do_op(8'h80, 8'h00, 4'b1101, 1'b1);   // R4 LSR -> 0x40
        do_op(8'h00, 8'h00, 4'b1000, 1'b0);   // R7 zero result, enable low
        do_op(8'h11, 8'h5A, 4'b0000, 1'b1);   // R5 move
        do_op(8'h11, 8'h00, 4'b0110, 1'b1);   // R5 unused code

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] x, y;
            logic [3:0] o;
            logic w;
            x = 8'($urandom);
            y = 8'($urandom);
            if (($urandom % 8) == 0) y = x;
            o = 4'($urandom);
            w = (($urandom % 4) != 0);
            do_op(x, y, o, w);
        end

        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check(cf == 1'b0 && zf == 1'b0, "R8 mid-run reset", {cf, zf}, 0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule